// File: doc/BRIEF.md
# Capture/Reload Timer with Baud Generation

This block is a 16-bit timer/counter paired with a 16-bit capture/reload register and an external trigger pin. A single control byte sets its behaviour. With both serial-clock select bits clear, it is either an auto-reload timer or a capture timer. With either serial-clock select bit set, it becomes a baud-rate source. In that case it reloads after every overflow and passes its overflow pulses to the serial receive and/or transmit tick outputs. Any tick output that is not selected passes through the overflow pulse of a neighbouring timer.

The count source is either a prescaled system clock or the falling edges of a count pin. The prescaler divides by 12 or by 4, as a rate bit selects. Software accesses the control byte, the rate byte, the two counter bytes and the two capture bytes through a plain byte-wide register port. Writes are single-cycle strobes, and read data is combinational from the address. Two sticky flags feed one interrupt request. The overflow flag is raised on overflow outside baud mode. The external flag is raised on an enabled trigger edge.

Top module: `cap_reload_timer`

## Requirements
- R1: After reset, all six registers read 0x00, `irq` is 0, and both tick outputs follow only `t1_ovf_i`.
- R2: Register addresses are 0 for control, 1 for rate, 2 and 3 for the counter low and high bytes, and 4 and 5 for the capture low and high bytes. The control bits from 7 to 0 are: overflow flag, external flag, receive-clock select, transmit-clock select, trigger enable, run, count-pin select, capture select. Only bit 5 of the rate register (fast prescale) is stored; its other bits read 0.
- R3: With run = 1 and count-pin select = 0, the counter advances once every 12 clocks when the rate bit is 0 and once every 4 clocks when it is 1. With run = 0 the counter holds its value.
- R4: With count-pin select = 1 and run = 1, the counter advances once per falling edge of `cnt_pin`. The pin passes through a two-flop synchronizer.
- R5: In capture mode (both clock selects 0, capture select 1), an overflow from 0xFFFF wraps the counter to 0x0000 and sets the overflow flag.
- R6: In reload mode (both clock selects 0, capture select 0), an overflow loads the counter from the capture register and sets the overflow flag.
- R7: With trigger enable = 1, a falling edge on `trig_pin` sets the external flag. In capture mode it also copies the counter into the capture register, and counting continues. In reload mode it also loads the counter from the capture register. With trigger enable = 0, the edge changes nothing.
- R8: In baud mode (either clock select 1), the capture select bit is ignored, every overflow reloads the counter from the capture register, and the overflow flag is never set by hardware.
- R9: `rx_tick` carries this timer's overflow pulse, delayed by one clock, when receive-clock select is 1, and `t1_ovf_i` otherwise. `tx_tick` does the same under transmit-clock select.
- R10: `irq` is the OR of the two flags. Each flag stays set until software writes 0 to it. A hardware set wins over a software write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| cnt_pin | input | 1 | External count input, falling edge counts |
| trig_pin | input | 1 | External capture/reload trigger, falling edge |
| t1_ovf_i | input | 1 | Overflow pulse of the neighbouring timer |
| rx_tick | output | 1 | Receive baud tick |
| tx_tick | output | 1 | Transmit baud tick |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: divide values of 12 and 4 and a two-stage pin synchronizer. With these values the exact number of prescaled steps in a fixed window can be predicted, and a two-count baud period gives an easily counted tick train. Overflow, capture and reload cases are driven through the count pin. This fixes exactly when the counter steps, so the bench can set up the 0xFFFF boundary and trigger edges without depending on the prescaler phase.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_RATE   = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_CAP_LO = 3'd4;
  localparam logic [ADDR_W-1:0] A_CAP_HI = 3'd5;

  localparam int RATE_FAST_BIT = 5;

  // first field is bit 7
  typedef struct packed {
    logic tf;       // overflow flag
    logic exf;      // external trigger flag
    logic rclk;     // receive clock select
    logic tclk;     // transmit clock select
    logic exen;     // trigger enable
    logic run;      // run control
    logic pin_sel;  // count pin select
    logic cap_sel;  // capture select
  } ctrl_t;

  typedef enum logic [1:0] {
    MODE_RELOAD  = 2'd0,
    MODE_CAPTURE = 2'd1,
    MODE_BAUD    = 2'd2
  } tmr_mode_e;

  function automatic tmr_mode_e decode_mode(ctrl_t c);
    if (c.rclk || c.tclk) return MODE_BAUD;
    else if (c.cap_sel)   return MODE_CAPTURE;
    else                  return MODE_RELOAD;
  endfunction
endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fell
);
  localparam int SH_W = STAGES + 1;
  logic [SH_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= {sh_q[SH_W-2:0], pin};
  end

  assign fell = sh_q[SH_W-1] & ~sh_q[SH_W-2];

  AST_FELL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fell |=> !fell); // R4
endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int SLOW_DIV = 12,
  parameter int FAST_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fast,
  output logic tick
);
  localparam int MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int PW = $clog2(MAX_DIV);
  localparam logic [PW-1:0] SLOW_LAST = PW'(SLOW_DIV - 1);
  localparam logic [PW-1:0] FAST_LAST = PW'(FAST_DIV - 1);

  logic [PW-1:0] presc_q;
  logic [PW-1:0] last;

  assign last = fast ? FAST_LAST : SLOW_LAST;
  assign tick = run && (presc_q >= last);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) presc_q <= '0;
    else if (tick)      presc_q <= '0;
    else                presc_q <= presc_q + 1'b1;
  end

  AST_PRESC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    presc_q <= SLOW_LAST || presc_q <= FAST_LAST); // R3
  AST_PRESC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> presc_q == '0); // R3
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  ovf_reload,
  input  logic                  trig_reload,
  input  logic [2*BYTE_W-1:0]   reload_val,
  input  logic                  wr_lo,
  input  logic                  wr_hi,
  input  logic [BYTE_W-1:0]     wdata,
  output logic [2*BYTE_W-1:0]   count,
  output logic                  ovf
);
  localparam int CNT_W = 2 * BYTE_W;
  logic [CNT_W-1:0] cnt_q;
  logic sw_wr;

  assign sw_wr = wr_lo | wr_hi;
  assign ovf   = en && (&cnt_q);
  assign count = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (sw_wr) begin
      if (wr_lo) cnt_q[BYTE_W-1:0]     <= wdata;
      if (wr_hi) cnt_q[CNT_W-1:BYTE_W] <= wdata;
    end else if (trig_reload) begin
      cnt_q <= reload_val;
    end else if (ovf) begin
      cnt_q <= ovf_reload ? reload_val : '0;
    end else if (en) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_OVF_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && ovf_reload && !sw_wr && !trig_reload) |=> cnt_q == $past(reload_val)); // R6
  AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_reload && !sw_wr && !trig_reload) |=> cnt_q == '0); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !trig_reload && !sw_wr) |=> $stable(cnt_q)); // R3
endmodule

// File: rtl/tmr_ctrl_regs.sv
module tmr_ctrl_regs
  import tmr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_ctrl,
  input  logic                wr_rate,
  input  logic                wr_cap_lo,
  input  logic                wr_cap_hi,
  input  logic [BYTE_W-1:0]   wdata,
  input  logic                set_tf,
  input  logic                set_exf,
  input  logic                capture,
  input  logic [2*BYTE_W-1:0] count,
  output ctrl_t               ctrl,
  output logic                fast,
  output logic [2*BYTE_W-1:0] cap
);
  localparam int CNT_W = 2 * BYTE_W;
  ctrl_t ctrl_q, ctrl_d;
  logic fast_q;
  logic [CNT_W-1:0] cap_q;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = ctrl_t'(wdata);
    if (set_tf)  ctrl_d.tf  = 1'b1;
    if (set_exf) ctrl_d.exf = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      fast_q <= 1'b0;
      cap_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      if (wr_rate) fast_q <= wdata[RATE_FAST_BIT];
      if (capture) cap_q <= count;
      else begin
        if (wr_cap_lo) cap_q[BYTE_W-1:0]     <= wdata;
        if (wr_cap_hi) cap_q[CNT_W-1:BYTE_W] <= wdata;
      end
    end
  end

  assign ctrl = ctrl_q;
  assign fast = fast_q;
  assign cap  = cap_q;

  AST_TF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.tf && !wr_ctrl) |=> ctrl_q.tf); // R10
  AST_EXF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_exf |=> ctrl_q.exf); // R7
  AST_CAPTURE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> cap_q == $past(count)); // R7
endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer
  import tmr_pkg::*;
#(
  parameter int SLOW_DIV    = 12,
  parameter int FAST_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              cnt_pin,
  input  logic              trig_pin,
  input  logic              t1_ovf_i,
  output logic              rx_tick,
  output logic              tx_tick,
  output logic              irq
);
  localparam int CNT_W = 2 * BYTE_W;
  localparam int N_PINS = 2;
  localparam int PIN_CNT = 0;
  localparam int PIN_TRIG = 1;

  ctrl_t            ctrl;
  tmr_mode_e        mode;
  logic             fast, presc_tick, cnt_en, ovf, ovf_q;
  logic [CNT_W-1:0] count, cap;
  logic [N_PINS-1:0] pins_in, pins_fell;
  logic             trig_evt, trig_reload, trig_capture;
  logic             wr_ctrl, wr_rate, wr_cnt_lo, wr_cnt_hi, wr_cap_lo, wr_cap_hi;

  assign pins_in[PIN_CNT]  = cnt_pin;
  assign pins_in[PIN_TRIG] = trig_pin;

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (pins_in[p]),
      .fell (pins_fell[p])
    );
  end

  assign wr_ctrl   = reg_wr && (reg_addr == A_CTRL);
  assign wr_rate   = reg_wr && (reg_addr == A_RATE);
  assign wr_cnt_lo = reg_wr && (reg_addr == A_CNT_LO);
  assign wr_cnt_hi = reg_wr && (reg_addr == A_CNT_HI);
  assign wr_cap_lo = reg_wr && (reg_addr == A_CAP_LO);
  assign wr_cap_hi = reg_wr && (reg_addr == A_CAP_HI);

  assign mode = decode_mode(ctrl);

  tmr_tick_gen #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (ctrl.run),
    .fast (fast),
    .tick (presc_tick)
  );

  assign cnt_en       = ctrl.run && (ctrl.pin_sel ? pins_fell[PIN_CNT] : presc_tick);
  assign trig_evt     = ctrl.exen && pins_fell[PIN_TRIG];
  assign trig_reload  = trig_evt && (mode == MODE_RELOAD);
  assign trig_capture = trig_evt && (mode == MODE_CAPTURE);

  tmr_count_core #(.BYTE_W(BYTE_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (cnt_en),
    .ovf_reload (mode != MODE_CAPTURE),
    .trig_reload(trig_reload),
    .reload_val (cap),
    .wr_lo      (wr_cnt_lo),
    .wr_hi      (wr_cnt_hi),
    .wdata      (reg_wdata),
    .count      (count),
    .ovf        (ovf)
  );

  tmr_ctrl_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ctrl  (wr_ctrl),
    .wr_rate  (wr_rate),
    .wr_cap_lo(wr_cap_lo),
    .wr_cap_hi(wr_cap_hi),
    .wdata    (reg_wdata),
    .set_tf   (ovf && (mode != MODE_BAUD)),
    .set_exf  (trig_evt),
    .capture  (trig_capture),
    .count    (count),
    .ctrl     (ctrl),
    .fast     (fast),
    .cap      (cap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf;
  end

  assign rx_tick = ctrl.rclk ? ovf_q : t1_ovf_i;
  assign tx_tick = ctrl.tclk ? ovf_q : t1_ovf_i;
  assign irq     = ctrl.tf | ctrl.exf;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:   reg_rdata = ctrl;
      A_RATE:   reg_rdata[RATE_FAST_BIT] = fast;
      A_CNT_LO: reg_rdata = count[BYTE_W-1:0];
      A_CNT_HI: reg_rdata = count[CNT_W-1:BYTE_W];
      A_CAP_LO: reg_rdata = cap[BYTE_W-1:0];
      A_CAP_HI: reg_rdata = cap[CNT_W-1:BYTE_W];
      default:  reg_rdata = '0;
    endcase
  end

  AST_BAUD_NO_TF: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctrl.rclk || ctrl.tclk) && !ctrl.tf && !wr_ctrl) |=> !ctrl.tf); // R8
  AST_OVF_SETS_TF: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ctrl.rclk && !ctrl.tclk) |=> ctrl.tf); // R5
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl.tf) |-> irq); // R10
endmodule

// File: tb/cap_reload_timer_tb.sv
module cap_reload_timer_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       cnt_pin = 1'b1;
  logic       trig_pin = 1'b1;
  logic       t1_ovf_i = 1'b0;
  logic       rx_tick, tx_tick, irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cap_reload_timer dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_pin(cnt_pin),
    .trig_pin(trig_pin), .t1_ovf_i(t1_ovf_i), .rx_tick(rx_tick),
    .tx_tick(tx_tick), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rd16(input logic [2:0] a_lo, output logic [15:0] d);
    logic [7:0] lo, hi;
    rd(a_lo, lo);
    rd(a_lo + 3'd1, hi);
    d = {hi, lo};
  endtask

  task automatic pulse_pin(input bit trig);
    @(negedge clk);
    if (trig) trig_pin = 1'b0; else cnt_pin = 1'b0;
    repeat (4) @(negedge clk);
    if (trig) trig_pin = 1'b1; else cnt_pin = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      check("R1 reset reg", 16'(d), 16'h0);
    end
    check("R1 reset irq", 16'(irq), 16'h0);
  endtask

  task automatic t_regmap();
    logic [7:0] d;
    logic [15:0] w;
    wr(3'd1, 8'hFF);
    rd(3'd1, d);
    check("R2 rate only fast bit", 16'(d), 16'h0020);
    wr(3'd4, 8'h34); wr(3'd5, 8'h12);
    rd16(3'd4, w);
    check("R2 capture bytes", w, 16'h1234);
    wr(3'd2, 8'hCD); wr(3'd3, 8'hAB);
    rd16(3'd2, w);
    check("R2 counter bytes", w, 16'hABCD);
    wr(3'd0, 8'h18);
    rd(3'd0, d);
    check("R2 control readback", 16'(d), 16'h0018);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_prescale(input bit fast_sel, input int hold);
    logic [15:0] w;
    wr(3'd1, fast_sel ? 8'h20 : 8'h00);
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wr(3'd0, 8'h04);
    repeat (hold) @(negedge clk);
    wr(3'd0, 8'h00);
    rd16(3'd2, w);
    check(fast_sel ? "R3 div4 steps" : "R3 div12 steps", w, 16'd10);
    repeat (30) @(negedge clk);
    rd16(3'd2, w);
    check("R3 hold when stopped", w, 16'd10);
  endtask

  task automatic t_pin_count();
    logic [15:0] w;
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wr(3'd0, 8'h06);
    for (int i = 0; i < 5; i++) pulse_pin(1'b0);
    repeat (20) @(negedge clk);
    rd16(3'd2, w);
    check("R4 count pin edges", w, 16'd5);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_capture_ovf();
    logic [15:0] w;
    logic [7:0] d;
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    wr(3'd0, 8'h07);
    pulse_pin(1'b0);
    rd16(3'd2, w);
    check("R5 wrap to zero", w, 16'h0000);
    repeat (5) @(negedge clk);
    rd(3'd0, d);
    check("R5 overflow flag", 16'(d), 16'h0087);
    check("R10 irq from overflow", 16'(irq), 16'h1);
    wr(3'd0, 8'h07);
    rd(3'd0, d);
    check("R10 flag cleared", 16'(d), 16'h0007);
    check("R10 irq cleared", 16'(irq), 16'h0);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_reload_ovf();
    logic [15:0] w;
    logic [7:0] d;
    wr(3'd4, 8'h34); wr(3'd5, 8'h12);
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    wr(3'd0, 8'h06);
    pulse_pin(1'b0);
    rd16(3'd2, w);
    check("R6 reload on overflow", w, 16'h1234);
    rd(3'd0, d);
    check("R6 overflow flag", 16'(d), 16'h0086);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_trigger();
    logic [15:0] w;
    logic [7:0] d;
    // capture with trigger enabled
    wr(3'd4, 8'h00); wr(3'd5, 8'h00);
    wr(3'd2, 8'h5A); wr(3'd3, 8'h5A);
    wr(3'd0, 8'h0F);
    pulse_pin(1'b1);
    rd16(3'd4, w);
    check("R7 capture copy", w, 16'h5A5A);
    rd(3'd0, d);
    check("R7 external flag", 16'(d), 16'h004F);
    check("R10 irq from external flag", 16'(irq), 16'h1);
    pulse_pin(1'b0);
    rd16(3'd2, w);
    check("R7 counting continues", w, 16'h5A5B);
    // trigger disabled
    wr(3'd0, 8'h07);
    wr(3'd4, 8'h00); wr(3'd5, 8'h00);
    pulse_pin(1'b1);
    rd16(3'd4, w);
    check("R7 disabled no capture", w, 16'h0000);
    rd(3'd0, d);
    check("R7 disabled no flag", 16'(d), 16'h0007);
    // reload by trigger
    wr(3'd4, 8'hCD); wr(3'd5, 8'hAB);
    wr(3'd2, 8'h00); wr(3'd3, 8'h01);
    wr(3'd0, 8'h0E);
    pulse_pin(1'b1);
    rd16(3'd2, w);
    check("R7 trigger reload", w, 16'hABCD);
    rd(3'd0, d);
    check("R7 reload flag", 16'(d), 16'h004E);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_baud(input bit use_rx);
    int ticks_sel = 0;
    int other_bad = 0;
    logic [7:0] d;
    wr(3'd1, 8'h20);
    wr(3'd4, 8'hFE); wr(3'd5, 8'hFF);
    wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
    t1_ovf_i = use_rx;
    // capture select set in rx case: must be ignored
    wr(3'd0, use_rx ? 8'h25 : 8'h14);
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (use_rx) begin
        if (rx_tick) ticks_sel++;
        if (tx_tick !== 1'b1) other_bad++;
      end else begin
        if (tx_tick) ticks_sel++;
        if (rx_tick !== 1'b0) other_bad++;
      end
    end
    check(use_rx ? "R9 rx baud ticks" : "R9 tx baud ticks", 16'(ticks_sel), 16'd10);
    check("R9 unselected follows t1", 16'(other_bad), 16'd0);
    rd(3'd0, d);
    check("R8 no overflow flag in baud", 16'(d), use_rx ? 16'h0025 : 16'h0014);
    wr(3'd0, 8'h00);
    t1_ovf_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_prescale(1'b1, 41);
    t_prescale(1'b0, 121);
    t_pin_count();
    t_capture_ovf();
    t_reload_ovf();
    t_trigger();
    t_baud(1'b1);
    t_baud(1'b0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule